// File: doc/BRIEF.md
# UTOPIA PHY-Side Transmit Cell Buffer

This block is the PHY-side slave on the transmit half of a UTOPIA link. An ATM-layer master writes 53-byte cells into it one byte per clock, using an active-low write enable and a start-of-cell flag. The block stores up to four complete cells. It releases each cell to a downstream framer over a valid/ready byte stream only after every byte of that cell has arrived. The stream marks the first and last byte of each cell.

A room indication (`tx_clav_o`) tells the master whether it may keep writing. It follows one of two flow-control rules, selected by a configuration bit. The octet rule guarantees room for at least four more bytes. The cell rule guarantees room for a whole further cell. A static pin sets the bit's value after reset, and a configuration write can change it later.

In multi-PHY operation the block answers only to its own 5-bit address. It latches selection from the address bus during idle cycles, and it always applies the cell rule. A mid-cell start-of-cell drops the partial cell and counts a runt. Writes that arrive while the buffer is full are discarded and raise a sticky overflow flag.

Top module: `utx_cell_buf`

## Requirements
- R1: The buffer holds at most 4 complete cells. Bytes written while 4 complete cells are stored are discarded and leave the stored cells unchanged.
- R2: `out_valid_o` rises only after the 53rd byte of a cell has been written; with fewer bytes written it stays low.
- R3: The downstream stream delivers each cell's 53 bytes in write order, with `out_first_o` high on byte 0 only and `out_last_o` high on byte 52 only. Cells leave in the order they were completed.
- R4: In octet mode (mode bit 0), `tx_clav_o` is high exactly when the free byte count is at least 4. Free bytes are (4 − stored cells) × 53 − bytes of the cell in progress.
- R5: In cell mode (mode bit 1), `tx_clav_o` is high exactly when stored cells plus one for a cell in progress is less than 4.
- R6: After reset the mode bit equals `mode_init_i`. A cycle with `cfg_we_i` high loads `cfg_cell_mode_i` into it, and that value then overrides `mode_init_i`.
- R7: A start-of-cell byte that arrives while a cell is partly written drops the partial cell and begins a new cell with that byte. It also increments `runt_cnt_o` by 1.
- R8: A byte without start-of-cell that arrives while no cell is in progress is discarded.
- R9: With `multi_phy_en_i` high, every cycle with `tx_enb_ni` high selects the block if `tx_addr_i` equals `phy_addr_i`, and deselects it otherwise. Address 31 never selects. Writes (`tx_enb_ni` low) are taken only while the block is selected.
- R10: With `multi_phy_en_i` high, `tx_clav_o` is 0 unless `tx_addr_i` equals `phy_addr_i` and is not 31. The cell rule (R5) applies whatever the mode bit holds.
- R11: With `multi_phy_en_i` low, `tx_addr_i` is ignored and every cycle with `tx_enb_ni` low is a write.
- R12: `ovf_o` is 0 after reset. It goes to 1 on a write attempt made while the buffer is full, and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_init_i | input | 1 | Mode bit value after reset (0 octet, 1 cell) |
| cfg_we_i | input | 1 | Loads the mode bit |
| cfg_cell_mode_i | input | 1 | Mode bit value to load |
| multi_phy_en_i | input | 1 | Enables address matching |
| phy_addr_i | input | 5 | Own PHY address |
| tx_addr_i | input | 5 | Address driven by the ATM layer |
| tx_enb_ni | input | 1 | Write enable, active low |
| tx_soc_i | input | 1 | Start of cell, marks byte 0 |
| tx_data_i | input | 8 | Write data byte |
| tx_clav_o | output | 1 | Room indication for the master |
| out_valid_o | output | 1 | Downstream byte valid |
| out_ready_i | input | 1 | Downstream byte accept |
| out_data_o | output | 8 | Downstream data byte |
| out_first_o | output | 1 | Byte 0 of a cell |
| out_last_o | output | 1 | Byte 52 of a cell |
| runt_cnt_o | output | 8 | Count of dropped partial cells, wraps |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest states to reach are near the threshold where the two flow-control rules disagree. With three cells stored and a fourth partly written, the cell rule must already report no room, while the octet rule still reports room until only three free bytes remain.

The bench gets there by filling the buffer with whole cells and then writing an exact number of extra bytes, holding the downstream side stalled the whole time. It then samples `tx_clav_o` one byte either side of each threshold. The multi-PHY scenario reaches the same state with the mode bit set to octet, which shows that address matching forces the cell rule. Writes made under a foreign address and under the null address are then shown to leave `out_valid_o` low.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int CELL_BYTES = 53;
  localparam int OCTET_MIN  = 4;
  localparam logic [4:0] NULL_ADDR = 5'd31;
endpackage

// File: rtl/utx_cell_mem.sv
module utx_cell_mem #(
  parameter int DEPTH  = 212,
  parameter int DATA_W = 8,
  parameter int AW     = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/utx_wr_ctrl.sv
module utx_wr_ctrl #(
  parameter int NUM_CELLS = 4,
  parameter int CELL_LEN  = 53,
  parameter int RUNT_W    = 8,
  localparam int SLOT_W   = $clog2(NUM_CELLS),
  localparam int BYTE_W   = $clog2(CELL_LEN),
  localparam int AW       = $clog2(NUM_CELLS * CELL_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              soc_i,
  input  logic              full_i,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              commit_o,
  output logic [BYTE_W-1:0] wr_cnt_o,
  output logic [RUNT_W-1:0] runt_cnt_o,
  output logic              ovf_o
);
  logic [SLOT_W-1:0] wr_slot_q;
  logic [BYTE_W-1:0] wr_cnt_q, byte_idx;
  logic [RUNT_W-1:0] runt_q;
  logic              ovf_q, in_cell, accept, runt_hit;

  assign in_cell  = (wr_cnt_q != '0);
  assign accept   = wr_i && !full_i && (soc_i || in_cell);
  assign runt_hit = accept && soc_i && in_cell;
  assign byte_idx = soc_i ? '0 : wr_cnt_q;
  assign commit_o = accept && (byte_idx == BYTE_W'(CELL_LEN - 1));
  assign mem_we_o = accept;

  always_comb begin
    mem_addr_o = AW'(wr_slot_q) * AW'(CELL_LEN) + AW'(byte_idx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_slot_q <= '0;
      wr_cnt_q  <= '0;
      runt_q    <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (accept) begin
        if (commit_o) begin
          wr_cnt_q  <= '0;
          wr_slot_q <= (wr_slot_q == SLOT_W'(NUM_CELLS - 1)) ? '0 : wr_slot_q + 1'b1;
        end else begin
          wr_cnt_q <= byte_idx + 1'b1;
        end
      end
      if (runt_hit) runt_q <= runt_q + 1'b1;
      if (wr_i && full_i) ovf_q <= 1'b1;
    end
  end

  assign wr_cnt_o   = wr_cnt_q;
  assign runt_cnt_o = runt_q;
  assign ovf_o      = ovf_q;

  AST_FULL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_i) |=> ($stable(wr_cnt_q) && $stable(wr_slot_q))); // R1
  AST_RUNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !full_i && soc_i && wr_cnt_q != '0) |=> (wr_cnt_q == BYTE_W'(1))); // R7
  AST_STRAY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !soc_i && wr_cnt_q == '0) |=> (wr_cnt_q == '0)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R12
endmodule

// File: rtl/utx_rd_ctrl.sv
module utx_rd_ctrl #(
  parameter int NUM_CELLS = 4,
  parameter int CELL_LEN  = 53,
  localparam int SLOT_W   = $clog2(NUM_CELLS),
  localparam int BYTE_W   = $clog2(CELL_LEN),
  localparam int AW       = $clog2(NUM_CELLS * CELL_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          avail_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic          first_o,
  output logic          last_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          release_o
);
  logic [SLOT_W-1:0] rd_slot_q;
  logic [BYTE_W-1:0] rd_cnt_q;
  logic              fire;

  assign valid_o   = avail_i;
  assign first_o   = (rd_cnt_q == '0);
  assign last_o    = (rd_cnt_q == BYTE_W'(CELL_LEN - 1));
  assign fire      = valid_o && ready_i;
  assign release_o = fire && last_o;

  always_comb begin
    mem_addr_o = AW'(rd_slot_q) * AW'(CELL_LEN) + AW'(rd_cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_slot_q <= '0;
      rd_cnt_q  <= '0;
    end else if (fire) begin
      if (last_o) begin
        rd_cnt_q  <= '0;
        rd_slot_q <= (rd_slot_q == SLOT_W'(NUM_CELLS - 1)) ? '0 : rd_slot_q + 1'b1;
      end else begin
        rd_cnt_q <= rd_cnt_q + 1'b1;
      end
    end
  end

  AST_CELL_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> (!valid_o || first_o)); // R3
  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> $stable(mem_addr_o)); // R3
endmodule

// File: rtl/utx_flow.sv
module utx_flow #(
  parameter int NUM_CELLS = 4,
  parameter int CELL_LEN  = 53,
  parameter int OCTET_MIN = 4,
  localparam int CNT_W    = $clog2(NUM_CELLS + 1) + 1,
  localparam int BYTE_W   = $clog2(CELL_LEN),
  localparam int FREE_W   = $clog2(NUM_CELLS * CELL_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_mode_i,
  input  logic [CNT_W-2:0]  cnt_i,
  input  logic [BYTE_W-1:0] wr_cnt_i,
  output logic              room_o
);
  logic [FREE_W-1:0] free_bytes;
  logic [CNT_W-1:0]  slots_used;

  always_comb begin
    free_bytes = (FREE_W'(NUM_CELLS) - FREE_W'(cnt_i)) * FREE_W'(CELL_LEN) - FREE_W'(wr_cnt_i);
    slots_used = CNT_W'(cnt_i) + CNT_W'(wr_cnt_i != '0);
    room_o     = cell_mode_i ? (slots_used < CNT_W'(NUM_CELLS))
                             : (free_bytes >= FREE_W'(OCTET_MIN));
  end

  AST_CELL_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_mode_i && room_o) |-> (free_bytes >= FREE_W'(CELL_LEN) + FREE_W'(wr_cnt_i != '0) * FREE_W'(CELL_LEN) - FREE_W'(wr_cnt_i))); // R5
  AST_OCTET_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cell_mode_i && !room_o) |-> (cnt_i != '0 || wr_cnt_i != '0)); // R4
endmodule

// File: rtl/utx_cell_buf.sv
module utx_cell_buf #(
  parameter int NUM_CELLS = 4,
  parameter int CELL_LEN  = utx_pkg::CELL_BYTES,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5,
  parameter int RUNT_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_init_i,
  input  logic              cfg_we_i,
  input  logic              cfg_cell_mode_i,
  input  logic              multi_phy_en_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] tx_addr_i,
  input  logic              tx_enb_ni,
  input  logic              tx_soc_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_clav_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_first_o,
  output logic              out_last_o,
  output logic [RUNT_W-1:0] runt_cnt_o,
  output logic              ovf_o
);
  localparam int DEPTH  = NUM_CELLS * CELL_LEN;
  localparam int AW     = $clog2(DEPTH);
  localparam int BYTE_W = $clog2(CELL_LEN);
  localparam int CNT_W  = $clog2(NUM_CELLS + 1);
  localparam logic [ADDR_W-1:0] NULL_A = ADDR_W'(utx_pkg::NULL_ADDR);

  logic              sel_q, sel, cfg_set_q, mode_q, cell_mode;
  logic              addr_hit, wr, full, commit, release_c, room;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] wr_cnt;
  logic              mem_we;
  logic [AW-1:0]     waddr, raddr;

  assign addr_hit  = (tx_addr_i == phy_addr_i) && (tx_addr_i != NULL_A);
  assign sel       = multi_phy_en_i ? sel_q : 1'b1;
  assign wr        = !tx_enb_ni && sel;
  assign full      = (cnt_q == CNT_W'(NUM_CELLS));
  assign cell_mode = multi_phy_en_i || (cfg_set_q ? mode_q : mode_init_i);
  assign tx_clav_o = room && (!multi_phy_en_i || addr_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= 1'b0;
      cfg_set_q <= 1'b0;
      mode_q    <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (multi_phy_en_i && tx_enb_ni) sel_q <= addr_hit;
      if (cfg_we_i) begin
        cfg_set_q <= 1'b1;
        mode_q    <= cfg_cell_mode_i;
      end
      case ({commit, release_c})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  utx_wr_ctrl #(.NUM_CELLS(NUM_CELLS), .CELL_LEN(CELL_LEN), .RUNT_W(RUNT_W)) u_wr (
    .clk_i, .rst_ni,
    .wr_i(wr), .soc_i(tx_soc_i), .full_i(full),
    .mem_we_o(mem_we), .mem_addr_o(waddr), .commit_o(commit),
    .wr_cnt_o(wr_cnt), .runt_cnt_o(runt_cnt_o), .ovf_o(ovf_o)
  );

  utx_rd_ctrl #(.NUM_CELLS(NUM_CELLS), .CELL_LEN(CELL_LEN)) u_rd (
    .clk_i, .rst_ni,
    .avail_i(cnt_q != '0), .ready_i(out_ready_i),
    .valid_o(out_valid_o), .first_o(out_first_o), .last_o(out_last_o),
    .mem_addr_o(raddr), .release_o(release_c)
  );

  utx_cell_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_mem (
    .clk_i,
    .we_i(mem_we), .waddr_i(waddr), .wdata_i(tx_data_i),
    .raddr_i(raddr), .rdata_o(out_data_o)
  );

  utx_flow #(.NUM_CELLS(NUM_CELLS), .CELL_LEN(CELL_LEN), .OCTET_MIN(utx_pkg::OCTET_MIN)) u_flow (
    .clk_i, .rst_ni,
    .cell_mode_i(cell_mode), .cnt_i(cnt_q), .wr_cnt_i(wr_cnt), .room_o(room)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> (wr_cnt == '0)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NUM_CELLS)); // R1
  AST_VISIBLE_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(commit)); // R2
  AST_NULL_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (multi_phy_en_i && tx_enb_ni && tx_addr_i == NULL_A) |=> !sel_q); // R9
  AST_CLAV_FOREIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (multi_phy_en_i && tx_addr_i != phy_addr_i) |-> !tx_clav_o); // R10
endmodule

// File: tb/tb_utx_cell_buf.sv
`timescale 1ns/1ps
module tb_utx_cell_buf;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_init = 1'b0, cfg_we = 1'b0, cfg_mode = 1'b0, multi = 1'b0;
  logic [4:0] phy_addr = 5'd5, tx_addr = 5'd9;
  logic tx_enb_n = 1'b1, tx_soc = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_clav, out_valid, out_ready = 1'b0, out_first, out_last, ovf;
  logic [7:0] out_data, runt_cnt;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  utx_cell_buf dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_init_i(mode_init), .cfg_we_i(cfg_we),
    .cfg_cell_mode_i(cfg_mode), .multi_phy_en_i(multi), .phy_addr_i(phy_addr),
    .tx_addr_i(tx_addr), .tx_enb_ni(tx_enb_n), .tx_soc_i(tx_soc), .tx_data_i(tx_data),
    .tx_clav_o(tx_clav), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_first_o(out_first), .out_last_o(out_last),
    .runt_cnt_o(runt_cnt), .ovf_o(ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int tag, input int i);
    return 8'(tag * 7 + i);
  endfunction

  task automatic do_reset();
    tx_enb_n = 1'b1; tx_soc = 1'b0; out_ready = 1'b0; cfg_we = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic s);
    tx_enb_n = 1'b0; tx_data = d; tx_soc = s;
    @(negedge clk);
    tx_enb_n = 1'b1; tx_soc = 1'b0;
  endtask

  task automatic wr_bytes(input int tag, input int first, input int n);
    for (int i = first; i < first + n; i++) wr_byte(pat(tag, i), i == 0);
  endtask

  task automatic rd_cell(input int tag, input string req);
    out_ready = 1'b1;
    for (int i = 0; i < 53; i++) begin
      chk({req, " valid"}, out_valid, 1);
      chk({req, " data"}, out_data, pat(tag, i));
      chk({req, " first"}, out_first, i == 0);
      chk({req, " last"}, out_last, i == 52);
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    mode_init = 1'b0; multi = 1'b0;
    do_reset();
    chk("R2 reset valid", out_valid, 0);
    chk("R4 reset clav", tx_clav, 1);
    chk("R12 reset ovf", ovf, 0);
    chk("R7 reset runt", runt_cnt, 0);
  endtask

  task automatic t_octet();
    do_reset();
    wr_bytes(0, 0, 52);
    chk("R2 52 bytes not visible", out_valid, 0);
    wr_bytes(0, 52, 1);
    chk("R2 53rd byte visible", out_valid, 1);
    wr_bytes(1, 0, 53);
    wr_bytes(2, 0, 53);
    wr_bytes(3, 0, 49);
    chk("R4 free=4 clav", tx_clav, 1);
    wr_bytes(3, 49, 1);
    chk("R4 free=3 clav", tx_clav, 0);
    wr_bytes(3, 50, 3);
    chk("R4 full clav", tx_clav, 0);
    chk("R12 no ovf yet", ovf, 0);
    wr_byte(8'hA5, 1'b1);
    wr_byte(8'h5A, 1'b0);
    chk("R12 ovf set", ovf, 1);
    chk("R1 runt not counted on full", runt_cnt, 0);
    for (int c = 0; c < 4; c++) rd_cell(c, "R1 R3 cell");
    chk("R3 empty after drain", out_valid, 0);
    chk("R12 ovf sticky", ovf, 1);
  endtask

  task automatic t_cell();
    do_reset();
    cfg_mode = 1'b1; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R5 empty clav", tx_clav, 1);
    for (int c = 0; c < 3; c++) wr_bytes(c + 4, 0, 53);
    chk("R5 3 cells clav", tx_clav, 1);
    wr_bytes(7, 0, 1);
    chk("R6 R5 3 cells+1 byte clav", tx_clav, 0);
    rd_cell(4, "R5 cell");
    chk("R5 slot freed clav", tx_clav, 1);
    wr_bytes(7, 1, 52);
    for (int c = 5; c < 8; c++) rd_cell(c, "R5 cell");
  endtask

  task automatic t_runt();
    do_reset();
    wr_bytes(12, 0, 20);
    wr_bytes(13, 0, 52);
    chk("R7 runt count", runt_cnt, 1);
    chk("R7 restart not visible", out_valid, 0);
    wr_bytes(13, 52, 1);
    chk("R7 restart visible", out_valid, 1);
    rd_cell(13, "R7 cell");
  endtask

  task automatic t_stray();
    do_reset();
    tx_addr = 5'd9; // R11 foreign address ignored in single-PHY mode
    for (int i = 0; i < 5; i++) wr_byte(8'hEE, 1'b0);
    chk("R8 stray clav", tx_clav, 1);
    wr_bytes(11, 0, 52);
    chk("R8 stray not counted", out_valid, 0);
    wr_bytes(11, 52, 1);
    chk("R11 write with foreign addr", out_valid, 1);
    rd_cell(11, "R8 cell");
  endtask

  task automatic sel_phy(input logic [4:0] a);
    tx_addr = a; tx_enb_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_multi();
    multi = 1'b1; phy_addr = 5'd5;
    do_reset();
    sel_phy(5'd5);
    chk("R10 own addr clav", tx_clav, 1);
    tx_addr = 5'd6;
    #1 chk("R10 foreign addr clav", tx_clav, 0);
    sel_phy(5'd6);
    wr_bytes(20, 0, 53);
    chk("R9 foreign writes ignored", out_valid, 0);
    sel_phy(5'd31);
    chk("R10 null addr clav", tx_clav, 0);
    wr_bytes(21, 0, 53);
    chk("R9 null writes ignored", out_valid, 0);
    sel_phy(5'd5);
    for (int c = 0; c < 3; c++) wr_bytes(c + 22, 0, 53);
    wr_bytes(25, 0, 1);
    chk("R10 forced cell rule", tx_clav, 0);
    for (int c = 0; c < 3; c++) rd_cell(c + 22, "R9 cell");
    multi = 1'b0; tx_addr = 5'd9;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    t_reset();
    t_octet();
    t_cell();
    t_runt();
    t_stray();
    t_multi();
    do_reset();
    chk("R12 ovf cleared by reset", ovf, 0);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end
endmodule